// File: doc/BRIEF.md
# Oscillator Frequency Window Monitor

This block checks that an oscillating input runs within an allowed frequency band. It takes the monitored signal into the reference clock domain and counts its rising edges over a gate window. The window is a fixed number of reference clock cycles. At the end of each window the edge count is compared with a lower and an upper edge limit. Each limit is derived from a frequency limit, the window length and the reference frequency.

Either kind of violation sets one latched fault flag, so an input that is too slow cannot be told apart from one that is too fast. Software clears the flag by writing a zero to it. A synchronous reset also clears it. A monitor-enable input starts and stops the measurement. While the monitor is disabled, the edge count is held at zero and no new fault can be raised. A fault that was already latched stays set.

With the default parameters, a 16 MHz reference and a 1600-cycle gate (100 us), the 40 kHz and 1 MHz limits become edge limits of 4 and 100.

Top module: `osc_window_mon`

## Requirements
- R1: If the edge count of a completed window is below the lower edge limit (LO_HZ*GATE_CYCLES/REF_HZ, 4 by default), `fault_o` becomes 1.
- R2: If the edge count of a completed window is above the upper edge limit (HI_HZ*GATE_CYCLES/REF_HZ, 100 by default), `fault_o` becomes 1.
- R3: A window whose edge count lies between the two limits, both limits included, does not set `fault_o`.
- R4: Under-frequency and over-frequency drive the same single output `fault_o`. No other output tells the two apart.
- R5: Once set, `fault_o` stays 1 until one of two things happens. Either a write with `flag_wr_i`=1 and `flag_wdata_i`=0 clears it on the next clock edge, or `rst_i` is asserted. A write with `flag_wdata_i`=1 leaves the flag unchanged.
- R6: While `mon_en_i`=0, the edge count is held at zero and `fault_o` cannot become set. An already set `fault_o` is kept.
- R7: An input that does not toggle at all during a window (zero edges) is treated as under-frequency and sets `fault_o`.
- R8: After `mon_en_i` rises, the first window starts from a zero count. That window lasts GATE_CYCLES reference cycles, so no verdict appears earlier than GATE_CYCLES cycles after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mon_en_i | input | 1 | Monitoring enable |
| osc_i | input | 1 | Monitored oscillation, asynchronous to clk_i |
| flag_wr_i | input | 1 | Write strobe for the fault flag |
| flag_wdata_i | input | 1 | Value written; 0 clears the flag |
| fault_o | output | 1 | Latched out-of-window fault flag |

## Verification
The input is driven as a square wave whose half-period is swept from one reference cycle up to several hundred, and also held still. The sweep includes half-periods that give exactly 100 and exactly 4 edges per window. These separate the inclusive boundaries from their off-by-one neighbours on both sides. Fast and slow cases raise the same flag, which shows the single shared fault. The stopped input shows that zero edges count as under-frequency. Separate sequences check the first-window timing after enable, the disabled hold, and the clear semantics: a zero write clears the flag, a one write does not, and reset clears it.

// File: rtl/osc_mon_pkg.sv
package osc_mon_pkg;

    // Verdict of one completed gate window.
    typedef struct packed {
        logic under;
        logic over;
    } verdict_t;

    // Phase of the gate timer.
    typedef enum logic [1:0] {
        GATE_OFF  = 2'd0,
        GATE_RUN  = 2'd1,
        GATE_LAST = 2'd2
    } gate_phase_t;

    // Edge count that corresponds to a frequency over a gate of given length.
    function automatic int unsigned edge_limit(longint unsigned hz,
                                               longint unsigned gate,
                                               longint unsigned ref_hz);
        longint unsigned prod;
        prod = hz * gate;
        return int'(prod / ref_hz);
    endfunction

    // Width needed to hold every edge count a window can produce.
    function automatic int unsigned count_width(int unsigned gate);
        return $clog2(gate + 2);
    endfunction

    // Saturating increment by a single bit.
    function automatic logic [31:0] sat_add(logic [31:0] a, logic inc,
                                            logic [31:0] max);
        if (inc && (a != max)) begin
            return a + 32'd1;
        end
        return a;
    endfunction

endpackage

// File: rtl/osc_sync.sv
module osc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[0] <= 1'b0;
                    else       chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[s] <= 1'b0;
                    else       chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/osc_gate_timer.sv
module osc_gate_timer
    import osc_mon_pkg::*;
#(
    parameter int unsigned GATE_CYCLES = 1600
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    output logic win_end_o
);
    localparam int unsigned TW = $clog2(GATE_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);

    logic [TW-1:0] tick_q;
    gate_phase_t   phase;

    always_comb begin
        if (!en_i)               phase = GATE_OFF;
        else if (tick_q == LAST) phase = GATE_LAST;
        else                     phase = GATE_RUN;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tick_q <= '0;
        end else begin
            unique case (phase)
                GATE_OFF:  tick_q <= '0;
                GATE_LAST: tick_q <= '0;
                default:   tick_q <= tick_q + TW'(1);
            endcase
        end
    end

    assign win_end_o = (phase == GATE_LAST);
endmodule

// File: rtl/osc_edge_counter.sv
module osc_edge_counter
    import osc_mon_pkg::*;
#(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             sig_i,
    input  logic             win_end_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] total_o
);
    localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);

    logic             prev_q;
    logic             rise;
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      sum;

    // The previous sample tracks the input while disabled, so enabling
    // never creates a false edge.
    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= sig_i;
    end

    assign rise = en_i && sig_i && !prev_q;
    assign sum  = sat_add(32'(cnt_q), rise, CNT_MAX);

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            cnt_q <= '0;
        end else if (win_end_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= CNT_W'(sum);
        end
    end

    assign count_o = cnt_q;
    assign total_o = CNT_W'(sum);
endmodule

// File: rtl/osc_window_judge.sv
module osc_window_judge
    import osc_mon_pkg::*;
#(
    parameter int unsigned CNT_W  = 11,
    parameter int unsigned LO_CNT = 4,
    parameter int unsigned HI_CNT = 100
) (
    input  logic [CNT_W-1:0] total_i,
    output verdict_t         verdict_o
);
    localparam logic [31:0] LO = 32'(LO_CNT);
    localparam logic [31:0] HI = 32'(HI_CNT);

    always_comb begin
        verdict_o.under = (32'(total_i) < LO);
        verdict_o.over  = (32'(total_i) > HI);
    end
endmodule

// File: rtl/osc_window_mon.sv
module osc_window_mon
    import osc_mon_pkg::*;
#(
    parameter int unsigned REF_HZ      = 16_000_000,
    parameter int unsigned GATE_CYCLES = 1600,
    parameter int unsigned LO_HZ       = 40_000,
    parameter int unsigned HI_HZ       = 1_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mon_en_i,
    input  logic osc_i,
    input  logic flag_wr_i,
    input  logic flag_wdata_i,
    output logic fault_o
);
    localparam int unsigned CNT_W  = count_width(GATE_CYCLES);
    localparam int unsigned LO_CNT = edge_limit(LO_HZ, GATE_CYCLES, REF_HZ);
    localparam int unsigned HI_CNT = edge_limit(HI_HZ, GATE_CYCLES, REF_HZ);

    logic             osc_sync;
    logic             win_end;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] edge_total;
    verdict_t         verdict;
    logic             violation;
    logic             fault_q;

    osc_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (osc_i),
        .sync_o  (osc_sync)
    );

    osc_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) gate_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (mon_en_i),
        .win_end_o (win_end)
    );

    osc_edge_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (mon_en_i),
        .sig_i     (osc_sync),
        .win_end_i (win_end),
        .count_o   (edge_cnt),
        .total_o   (edge_total)
    );

    osc_window_judge #(
        .CNT_W  (CNT_W),
        .LO_CNT (LO_CNT),
        .HI_CNT (HI_CNT)
    ) judge_i (
        .total_i   (edge_total),
        .verdict_o (verdict)
    );

    assign violation = verdict.under | verdict.over;

    // A new fault wins over a clear in the same cycle.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fault_q <= 1'b0;
        end else if (mon_en_i && win_end && violation) begin
            fault_q <= 1'b1;
        end else if (flag_wr_i && !flag_wdata_i) begin
            fault_q <= 1'b0;
        end
    end

    assign fault_o = fault_q;
endmodule

// File: rtl/osc_window_mon_chk.sv
module osc_window_mon_chk #(
    parameter int unsigned CNT_W = 11
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             mon_en_i,
    input logic             flag_wr_i,
    input logic             flag_wdata_i,
    input logic             fault_o,
    input logic             win_end,
    input logic             violation,
    input logic [CNT_W-1:0] edge_cnt
);
    AST_SET_ON_VIOLATION: assert property (@(posedge clk_i) disable iff (rst_i)
        mon_en_i && win_end && violation |=> fault_o); // R1
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (rst_i)
        !fault_o && !(mon_en_i && win_end && violation) |=> !fault_o); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        fault_o && !(flag_wr_i && !flag_wdata_i) |=> fault_o); // R5
    AST_ZERO_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        flag_wr_i && !flag_wdata_i && !(mon_en_i && win_end && violation)
        |=> !fault_o); // R5
    AST_DISABLED_NO_SET: assert property (@(posedge clk_i) disable iff (rst_i)
        !mon_en_i && !fault_o |=> !fault_o); // R6
    AST_DISABLED_CNT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !mon_en_i |=> edge_cnt == '0); // R6
    AST_NO_END_WHEN_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        !mon_en_i |-> !win_end); // R8
endmodule

bind osc_window_mon osc_window_mon_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .mon_en_i     (mon_en_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .fault_o      (fault_o),
    .win_end      (win_end),
    .violation    (violation),
    .edge_cnt     (edge_cnt)
);

// File: tb/osc_window_mon_tb.sv
module osc_window_mon_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REF_HZ     = 16_000_000;
    localparam int GATE       = 1600;
    localparam int LO_HZ      = 40_000;
    localparam int HI_HZ      = 1_000_000;
    localparam int LO_EDGES   = LO_HZ / 1000 * GATE / (REF_HZ / 1000);
    localparam int HI_EDGES   = HI_HZ / 1000 * GATE / (REF_HZ / 1000);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic osc = 1'b0;
    logic wr = 1'b0;
    logic wd = 1'b0;
    logic fault;

    int half = 0;    // 0 = stopped input
    int phase_cnt = 0;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_window_mon #(
        .REF_HZ(REF_HZ), .GATE_CYCLES(GATE), .LO_HZ(LO_HZ), .HI_HZ(HI_HZ),
        .SYNC_STAGES(2)
    ) dut_i (
        .clk_i(clk), .rst_i(rst), .mon_en_i(en), .osc_i(osc),
        .flag_wr_i(wr), .flag_wdata_i(wd), .fault_o(fault)
    );

    // Square-wave source, changes away from the active edge.
    always @(negedge clk) begin
        if (half > 0) begin
            if (phase_cnt + 1 >= half) begin
                phase_cnt <= 0;
                osc <= ~osc;
            end else begin
                phase_cnt <= phase_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_flag(input logic v);
        @(negedge clk);
        wr = 1'b1; wd = v;
        @(negedge clk);
        wr = 1'b0; wd = 1'b0;
    endtask

    task automatic restart(input int h);
        en = 1'b0;
        write_flag(1'b0);
        half = h;
        cycles(20);
        en = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int hs[13] = '{1, 3, 7, 8, 9, 20, 100, 150, 200, 201, 267, 400, 800};
        cycles(5);
        rst = 1'b0;
        cycles(2);
        check(fault == 1'b0, "R5 reset state", fault, 0);

        // Sweep of half-periods; boundary cases 8 (100 edges) and 200 (4 edges).
        foreach (hs[i]) begin
            int p, fl, cl, exp;
            p  = 2 * hs[i];
            fl = GATE / p;
            cl = (GATE + p - 1) / p;
            restart(hs[i]);
            cycles(3 * GATE);
            if (fl >= LO_EDGES && cl <= HI_EDGES) begin
                exp = 0;
                check(fault == 1'b0, "R3 in-window count", fault, exp);
            end else if (cl < LO_EDGES) begin
                check(fault == 1'b1, "R1 under-frequency", fault, 1);
            end else if (fl > HI_EDGES) begin
                check(fault == 1'b1, "R2 over-frequency R4 shared flag", fault, 1);
            end
        end

        // R7: stopped input; R8: verdict timing from enable.
        restart(0);
        cycles(GATE - 10);
        check(fault == 1'b0, "R8 no verdict before first window ends", fault, 0);
        cycles(20);
        check(fault == 1'b1, "R7 zero edges is under-frequency", fault, 1);

        // R5: sticky, write-one ignored, write-zero clears.
        half = 20;
        cycles(2 * GATE);
        check(fault == 1'b1, "R5 flag stays after good input", fault, 1);
        write_flag(1'b1);
        cycles(1);
        check(fault == 1'b1, "R5 write of one ignored", fault, 1);
        write_flag(1'b0);
        check(fault == 1'b0, "R5 write of zero clears", fault, 0);
        cycles(2 * GATE);
        check(fault == 1'b0, "R3 stays clear with good input", fault, 0);

        // R6: disabled blocks new faults.
        en = 1'b0;
        half = 0;
        cycles(3 * GATE);
        check(fault == 1'b0, "R6 no fault while disabled", fault, 0);
        // R8: enable with good input after fast input while disabled.
        half = 1;
        cycles(3 * GATE);
        half = 20;
        cycles(4);
        en = 1'b1;
        cycles(GATE + 30);
        check(fault == 1'b0, "R8 first window starts from zero", fault, 0);

        // R6: existing flag held while disabled.
        half = 0;
        cycles(2 * GATE);
        check(fault == 1'b1, "R7 stop sets flag", fault, 1);
        en = 1'b0;
        half = 20;
        cycles(2 * GATE);
        check(fault == 1'b1, "R6 flag kept while disabled", fault, 1);

        // R5: reset clears.
        @(negedge clk);
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        cycles(1);
        check(fault == 1'b0, "R5 reset clears flag", fault, 0);

        finish_run();
    end
endmodule